// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Timing Unit

This block turns the per-byte mask pins of a synchronous DRAM data bus into per-lane controls, and applies the two different mask timings that such a bus needs. The data bus is split into 8-bit lanes, and each lane has one mask bit. On a write, the mask bit sampled with a data word decides whether that word's byte is stored. On a read, the mask bit decides whether the lane's output driver is on, but only for the data returned two clocks after the mask was sampled.

A controller-side model or a memory model places the unit between its command decoder and its storage array. Each cycle it supplies the mask bits, a write-data-valid flag, a read-in-progress flag and the clock-enable level. The write path registers the mask and the data together, so a byte enable and the byte it qualifies always come out in the same cycle. The read path delays the mask through a short shift pipeline. When the read-in-progress flag drops, every lane goes to high impedance two clocks later. A clock edge with clock enable low is treated as an edge that never happened.

Top module: `sdram_bytemask`

## Requirements
- R1: Mask bit i governs data bits [8i+7:8i] only, on both the write path and the read path. With 32 data bits there are 4 lanes.
- R2: On an edge with cke=1 and wr_act=1, the next wr_be_o equals the bitwise inverse of dqm (mask bit 0 gives an enabled lane), and wr_data_o equals the wdata of that same edge.
- R3: On an edge with cke=0 or wr_act=0, the next wr_be_o is all zeros. On an edge with cke=0, wr_data_o keeps its value.
- R4: rd_oe_o[i] is 1 when the second-most-recent edge with cke=1 sampled rd_act=1 and dqm[i]=0. In steady running, this means the mask gates the read data presented two clocks after the mask.
- R5: On each lane, rd_dq_o carries that lane of rdata when rd_oe_o is 1 for the lane, and carries zero when it is 0.
- R6: When rd_act is low on an edge with cke=1, all lanes of rd_oe_o are 0 two clocks later (high impedance after a burst).
- R7: An edge with cke=0 leaves rd_oe_o and the internal read pipeline unchanged.
- R8: The edge after a cycle with rst=1 gives rd_oe_o=0 and wr_be_o=0, and the read pipeline is cleared so that every lane is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; an edge with cke low is ignored |
| wr_act | input | 1 | Write data is present in this cycle |
| rd_act | input | 1 | A read burst is in progress in this cycle |
| dqm | input | LANES | Per-lane mask, 1 = masked |
| wdata | input | DATA_W | Write data from the bus |
| rdata | input | DATA_W | Read data from the array |
| wr_be_o | output | LANES | Registered per-lane write enables |
| wr_data_o | output | DATA_W | Write data registered alongside wr_be_o |
| rd_oe_o | output | LANES | Per-lane output driver enables |
| rd_dq_o | output | DATA_W | Read data with disabled lanes forced to zero |

## Verification
The hardest state to reach from the ports is a read pipeline that holds two different masks at once, then stalls with cke low, then resumes. Only this state shows whether the mask lands on the correct data slot after a suspension. The stimulus table runs three reads in a row with different mask patterns, then drops cke for two cycles while changing dqm, rd_act and wr_act to values that would be visible if they leaked through. Clock enable then returns, and the mask order is checked as it drains. After that, a burst end is followed into high impedance, and a reset is applied while the pipeline is full of enabled lanes.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_RD_LAT = 2;
endpackage

// File: rtl/bm_wr_stage.sv
module bm_wr_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              wr_act,
  input  logic [LANES-1:0]  dqm,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      be_q   <= '0;
      data_q <= '0;
    end else begin
      if (cke && wr_act) be_q <= ~dqm;
      else               be_q <= '0;
      if (cke) data_q <= wdata;
    end
  end
endmodule

// File: rtl/bm_rd_pipe.sv
module bm_rd_pipe #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             rd_act,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] oe
);
  logic [LANES-1:0] stg [DEPTH];
  logic [LANES-1:0] head;

  assign head = rd_act ? ~dqm : '0;

  for (genvar d = 0; d < DEPTH; d++) begin : g_stage
    if (d == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)      stg[0] <= '0;
        else if (cke) stg[0] <= head;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)      stg[d] <= '0;
        else if (cke) stg[d] <= stg[d-1];
      end
    end
  end

  assign oe = stg[DEPTH-1];
endmodule

// File: rtl/bm_lane_gate.sv
module bm_lane_gate #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic [LANES-1:0] en,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*LANE_W +: LANE_W] = en[l] ? din[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sdram_bytemask.sv
module sdram_bytemask
  import bm_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned RD_LAT  = DEF_RD_LAT,
  localparam int unsigned LANES  = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              wr_act,
  input  logic              rd_act,
  input  logic [LANES-1:0]  dqm,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  wr_be_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  rd_oe_o,
  output logic [DATA_W-1:0] rd_dq_o
);
  bm_wr_stage #(.DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst(rst), .cke(cke), .wr_act(wr_act), .dqm(dqm),
    .wdata(wdata), .be_q(wr_be_o), .data_q(wr_data_o)
  );

  bm_rd_pipe #(.LANES(LANES), .DEPTH(RD_LAT)) u_rd (
    .clk(clk), .rst(rst), .cke(cke), .rd_act(rd_act), .dqm(dqm),
    .oe(rd_oe_o)
  );

  bm_lane_gate #(.LANE_W(BYTE_W), .LANES(LANES)) u_gate (
    .en(rd_oe_o), .din(rdata), .dout(rd_dq_o)
  );
endmodule

// File: rtl/bm_mask_checker.sv
module bm_mask_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              wr_act,
  input logic [LANES-1:0]  dqm,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [LANES-1:0]  wr_be_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [LANES-1:0]  rd_oe_o,
  input logic [DATA_W-1:0] rd_dq_o
);
  localparam int unsigned LW = DATA_W / LANES;

  assert_write_align_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cke && wr_act)) |->
      (wr_be_o == ~$past(dqm) && wr_data_o == $past(wdata)));

  assert_write_block_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!(cke && wr_act))) |-> (wr_be_o == '0));

  assert_pipe_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cke)) |-> $stable(rd_oe_o));

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (rd_oe_o == '0 && wr_be_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    assert_lane_pass_R5: assert property (@(posedge clk) disable iff (rst)
      rd_oe_o[l] |-> (rd_dq_o[l*LW +: LW] == rdata[l*LW +: LW]));
    assert_lane_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !rd_oe_o[l] |-> (rd_dq_o[l*LW +: LW] == '0));
  end
endmodule

bind sdram_bytemask bm_mask_checker #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .wr_act(wr_act), .dqm(dqm),
  .wdata(wdata), .rdata(rdata), .wr_be_o(wr_be_o), .wr_data_o(wr_data_o),
  .rd_oe_o(rd_oe_o), .rd_dq_o(rd_dq_o)
);

// File: tb/sdram_bytemask_test.sv
`timescale 1ns/1ps
module sdram_bytemask_test;
  localparam int unsigned DW = 32;
  localparam int unsigned LN = 4;
  localparam int unsigned NV = 12;
  // entry: {cke, wr_act, rd_act, dqm[3:0], wdata[31:0], rdata[31:0]}
  localparam logic [70:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,4'b0000,32'hA1B2C3D4,32'h00000000},
    {1'b1,1'b1,1'b0,4'b0001,32'h11223344,32'h00000000},
    {1'b1,1'b1,1'b0,4'b1010,32'h55667788,32'h00000000},
    {1'b1,1'b0,1'b1,4'b0000,32'h00000000,32'hDEADBEEF},
    {1'b1,1'b0,1'b1,4'b0100,32'h00000000,32'h01020304},
    {1'b1,1'b0,1'b1,4'b1000,32'h00000000,32'hCAFEF00D},
    {1'b0,1'b1,1'b1,4'b1111,32'h99999999,32'h12345678},
    {1'b0,1'b0,1'b1,4'b0000,32'h00000000,32'h87654321},
    {1'b1,1'b0,1'b1,4'b0011,32'h00000000,32'hFFFFFFFF},
    {1'b1,1'b0,1'b0,4'b0000,32'h00000000,32'hAAAA5555},
    {1'b1,1'b0,1'b0,4'b0000,32'h00000000,32'h5555AAAA},
    {1'b1,1'b1,1'b1,4'b0110,32'h0BADF00D,32'h13572468}
  };

  logic clk = 1'b0;
  logic rst, cke, wr_act, rd_act;
  logic [LN-1:0] dqm;
  logic [DW-1:0] wdata, rdata;
  logic [LN-1:0] wr_be_o, rd_oe_o;
  logic [DW-1:0] wr_data_o, rd_dq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [LN-1:0] m_s0, m_s1, m_be;
  logic [DW-1:0] m_wd;

  always #4 clk = ~clk;

  sdram_bytemask uut (
    .clk(clk), .rst(rst), .cke(cke), .wr_act(wr_act), .rd_act(rd_act),
    .dqm(dqm), .wdata(wdata), .rdata(rdata), .wr_be_o(wr_be_o),
    .wr_data_o(wr_data_o), .rd_oe_o(rd_oe_o), .rd_dq_o(rd_dq_o)
  );

  function automatic logic [DW-1:0] expand(input logic [LN-1:0] en);
    logic [DW-1:0] r;
    for (int l = 0; l < LN; l++) r[l*8 +: 8] = {8{en[l]}};
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_s0 = '0; m_s1 = '0; m_be = '0; m_wd = '0;
    end else begin
      m_be = (cke && wr_act) ? ~dqm : '0;
      if (cke) begin
        m_wd = wdata;
        m_s1 = m_s0;
        m_s0 = rd_act ? ~dqm : '0;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #2;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2/R3 write enables"}, DW'(wr_be_o), DW'(m_be));
    if (m_be != '0) check({tag, " R2 write data"}, wr_data_o, m_wd);
    check({tag, " R4/R6/R7 read enables"}, DW'(rd_oe_o), DW'(m_s1));
    check({tag, " R1/R5 read data"}, rd_dq_o, rdata & expand(m_s1));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_s0 = '0; m_s1 = '0; m_be = '0; m_wd = '0;
    rst = 1'b1; cke = 1'b1; wr_act = 1'b1; rd_act = 1'b1; dqm = '0;
    wdata = 32'hFFFFFFFF; rdata = 32'hFFFFFFFF;
    @(negedge clk);
    step(); step();
    // R8: reset state
    check("R8 reset write enables", DW'(wr_be_o), '0);
    check("R8 reset read enables", DW'(rd_oe_o), '0);
    check("R8 reset read data", rd_dq_o, '0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: R1..R7
    for (int i = 0; i < NV; i++) begin
      {cke, wr_act, rd_act, dqm, wdata, rdata} = VEC[i];
      step();
      check_all($sformatf("vec%0d", i));
      @(negedge clk);
    end

    // R6: burst ended, all lanes high impedance
    cke = 1'b1; wr_act = 1'b0; rd_act = 1'b0; dqm = '0; rdata = 32'hFFFFFFFF;
    step(); step();
    check("R6 lanes idle after burst", DW'(rd_oe_o), '0);
    check("R6 data quiet after burst", rd_dq_o, '0);
    @(negedge clk);

    // R8: reset while pipeline full of enabled lanes
    rd_act = 1'b1; wr_act = 1'b1; dqm = 4'b0000;
    step(); step();
    check("R4 full pipe before reset", DW'(rd_oe_o), DW'(4'b1111));
    @(negedge clk);
    rst = 1'b1;
    step();
    check("R8 mid-run reset read enables", DW'(rd_oe_o), '0);
    check("R8 mid-run reset write enables", DW'(wr_be_o), '0);
    @(negedge clk);
    rst = 1'b0; rd_act = 1'b0; wr_act = 1'b0;
    step();
    check("R8 pipeline cleared by reset", DW'(rd_oe_o), '0);
    @(negedge clk);

    // R1: single lane mask on read path, lane 3 only
    rd_act = 1'b1; dqm = 4'b0111; rdata = 32'hA5A5A5A5;
    step(); step();
    check("R1 lane3 only enabled", rd_dq_o, 32'hA5000000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule